// File: doc/BRIEF.md
# GPIO Expander Register Core

This block holds the register file and pin logic behind a 16-line serial-bus I/O expander. The lines are grouped into two 8-bit ports. Each port has four registers:

- a direction register;
- a latched input register;
- an output data register;
- a read inversion mask.

A bus-protocol engine outside this block turns serial transactions into a register index plus single-cycle write and read strobes. This core answers with one byte of read data on the cycle after the strobe.

Each pin has an output-enable and an output value, so a pad can be driven. Each pin also feeds a synchronized input back into the core. An active-low interrupt tells the bus master that an input pin no longer matches the value last latched for it. Reading that port's input register latches the live value again, and this releases the interrupt.

Top module: `gpx_core`

## Requirements
- R1: After reset, every pin is an input (`pin_oe_o` all 0) and `pin_o` is all 1. Read back, the direction and output registers hold 0xFF and the inversion masks hold 0x00. `int_no` is high.
- R2: The register index `cmd_i[2:1]` picks the register kind: 0 = input, 1 = output, 2 = inversion mask, 3 = direction. `cmd_i[0]` picks the port, and port p owns pins `8p+7..8p`. A `wr_i` pulse stores `wdata_i` at the clock edge, and a later read of the same index returns that byte.
- R3: A write to an input-register index (0 or 1) changes nothing. The live interrupt state and the data returned by reading that index are unaffected.
- R4: A direction bit of 0 makes its pin an output: `pin_oe_o` goes to 1 and `pin_o` shows the matching output-register bit. A direction bit of 1 makes the pin an input, with `pin_oe_o` at 0.
- R5: A `rd_i` pulse sets `rdata_o` from the edge at which the strobe is sampled, and the value holds until the next read. For input indices the value is the synchronized pin byte XOR the port's inversion mask. For all other indices it is the stored register.
- R6: At the end of reset, the input registers take the current pin state. Pins held steady through reset do not raise the interrupt.
- R7: `int_no` goes low while any input-direction pin differs from its latched input bit. A pin change reaches `int_no` after exactly two clock edges.
- R8: Reading a port's input register latches that port's pins and releases the interrupt for that port. A read of the other port leaves the mismatch in place.
- R9: If a pin returns to its latched value before any read, `int_no` returns high.
- R10: Pins set as outputs never cause the interrupt.
- R11: Each pin passes through a two-flop synchronizer. One clock edge after a pin change, `int_no` is still high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 3 | Register index: kind in [2:1], port in [0] |
| wr_i | input | 1 | Single-cycle write strobe |
| wdata_i | input | 8 | Write data |
| rd_i | input | 1 | Single-cycle read strobe |
| rdata_o | output | 8 | Read data, registered |
| pin_i | input | 16 | Raw pin inputs |
| pin_o | output | 16 | Pin output values |
| pin_oe_o | output | 16 | Pin output enables, 1 = drive |
| int_no | output | 1 | Interrupt, active low |

## Verification
Register writes, direction changes and output values are due one edge after the write strobe. Read data is due one edge after the read strobe. A pin change reaches the interrupt after two edges, and a recapturing read releases it after one. The bench drives every input at the falling edge and samples at the next falling edge after the edge that owns the result. For synchronizer latency it also samples after the first edge, to show that the interrupt has not yet moved. Pins are held for at least three edges before any input read, so the read data never depends on a value still in flight.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
  typedef enum logic [1:0] {
    REG_IN  = 2'd0,
    REG_OUT = 2'd1,
    REG_POL = 2'd2,
    REG_CFG = 2'd3
  } gpx_reg_e;
endpackage

// File: rtl/gpx_sync.sv
module gpx_sync #(
  parameter int WIDTH  = 16,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_i;
      else             stage_q[s] <= stage_q[(s > 0) ? s - 1 : 0];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpx_port.sv
module gpx_port
  import gpx_pkg::*;
#(
  parameter int W = 8
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     settled_i,
  input  logic [W-1:0] sync_i,
  input  logic     wr_i,
  input  logic     rd_i,
  input  logic     hit_i,
  input  gpx_reg_e reg_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] rdval_o,
  output logic [W-1:0] out_o,
  output logic [W-1:0] oe_o,
  output logic [W-1:0] mism_o
);
  logic [W-1:0] in_q, out_q, pol_q, cfg_q;
  logic wr_hit, rd_in;

  assign wr_hit = wr_i && hit_i;
  assign rd_in  = rd_i && hit_i && (reg_i == REG_IN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q <= '1;
      pol_q <= '0;
      cfg_q <= '1;
    end else if (wr_hit) begin
      case (reg_i)
        REG_OUT: out_q <= wdata_i;
        REG_POL: pol_q <= wdata_i;
        REG_CFG: cfg_q <= wdata_i;
        default: ;
      endcase
    end
  end

  // track pins until synchronizer is primed, then latch on input reads only
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   in_q <= '0;
    else if (!settled_i || rd_in)  in_q <= sync_i;
  end

  always_comb begin
    case (reg_i)
      REG_IN:  rdval_o = sync_i ^ pol_q;
      REG_OUT: rdval_o = out_q;
      REG_POL: rdval_o = pol_q;
      default: rdval_o = cfg_q;
    endcase
  end

  assign out_o  = out_q;
  assign oe_o   = ~cfg_q;
  assign mism_o = (sync_i ^ in_q) & cfg_q;

  a_r2_cfg_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_hit && reg_i == REG_CFG) |=> (oe_o == ~$past(wdata_i)));

  a_r3_in_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (settled_i && wr_hit && reg_i == REG_IN && !rd_i) |=> (in_q == $past(in_q)));

  a_r8_read_recapture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (settled_i && rd_in) |=> (in_q == $past(sync_i)));
endmodule

// File: rtl/gpx_core.sv
module gpx_core
  import gpx_pkg::*;
#(
  parameter int PORTS       = 2,
  parameter int PORT_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int PINS   = PORTS * PORT_W,
  localparam int PSEL_W = $clog2(PORTS),
  localparam int CMD_W  = PSEL_W + 2,
  localparam int CNT_W  = $clog2(SYNC_STAGES + 2)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CMD_W-1:0]  cmd_i,
  input  logic              wr_i,
  input  logic [PORT_W-1:0] wdata_i,
  input  logic              rd_i,
  output logic [PORT_W-1:0] rdata_o,
  input  logic [PINS-1:0]   pin_i,
  output logic [PINS-1:0]   pin_o,
  output logic [PINS-1:0]   pin_oe_o,
  output logic              int_no
);
  localparam logic [CNT_W-1:0] SETTLE = CNT_W'(SYNC_STAGES + 1);

  logic [PINS-1:0]   pin_sync, mism;
  logic [PSEL_W-1:0] psel;
  gpx_reg_e          rsel;
  logic [CNT_W-1:0]  settle_cnt;
  logic              settled;
  logic [PORT_W-1:0] rdval [PORTS];

  assign psel = cmd_i[PSEL_W-1:0];
  assign rsel = gpx_reg_e'(cmd_i[CMD_W-1:PSEL_W]);

  gpx_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(pin_i), .q_o(pin_sync)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               settle_cnt <= '0;
    else if (settle_cnt != SETTLE) settle_cnt <= settle_cnt + 1'b1;
  end
  assign settled = (settle_cnt == SETTLE);

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    gpx_port #(.W(PORT_W)) u_port (
      .clk_i,
      .rst_ni,
      .settled_i(settled),
      .sync_i   (pin_sync[p*PORT_W +: PORT_W]),
      .wr_i,
      .rd_i,
      .hit_i    (psel == PSEL_W'(p)),
      .reg_i    (rsel),
      .wdata_i,
      .rdval_o  (rdval[p]),
      .out_o    (pin_o[p*PORT_W +: PORT_W]),
      .oe_o     (pin_oe_o[p*PORT_W +: PORT_W]),
      .mism_o   (mism[p*PORT_W +: PORT_W])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (rd_i) rdata_o <= rdval[psel];
  end

  assign int_no = ~(settled && (|mism));

  a_r6_int_masked_until_settled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !settled |-> int_no);

  a_r10_outputs_never_interrupt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_oe_o == '1) |-> int_no);
endmodule

// File: tb/gpx_core_tb.sv
module gpx_core_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [2:0]  cmd = 0;
  logic        wr = 0, rd = 0;
  logic [7:0]  wdata = 0;
  logic [7:0]  rdata;
  logic [15:0] pins = 16'h5AC3;
  logic [15:0] pout, poe;
  logic        intn;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  gpx_core u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_i(cmd), .wr_i(wr), .wdata_i(wdata),
    .rd_i(rd), .rdata_o(rdata), .pin_i(pins), .pin_o(pout), .pin_oe_o(poe),
    .int_no(intn)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr_reg(input logic [2:0] idx, input logic [7:0] d);
    cmd = idx; wdata = d; wr = 1;
    @(negedge clk);
    wr = 0;
  endtask

  task automatic rd_reg(input logic [2:0] idx, output logic [7:0] d);
    cmd = idx; rd = 1;
    @(negedge clk);
    rd = 0;
    d = rdata;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    chk("R1 oe", poe, 16'h0000);
    chk("R1 pin_o", pout, 16'hFFFF);
    chk("R1 int", intn, 1'b1);
    for (int i = 2; i < 8; i++) begin
      rd_reg(3'(i), v);
      chk("R1 regs", v, (i >= 4 && i < 6) ? 8'h00 : 8'hFF);
    end
    rd_reg(3'd0, v); chk("R6 in0 at reset", v, 8'hC3);
    rd_reg(3'd1, v); chk("R6 in1 at reset", v, 8'h5A);
    chk("R6 no int", intn, 1'b1);
  endtask

  task automatic t_regmap;
    logic [7:0] v;
    wr_reg(3'd2, 8'h3C); wr_reg(3'd3, 8'hA1);
    wr_reg(3'd4, 8'h0F); wr_reg(3'd5, 8'hF0);
    rd_reg(3'd2, v); chk("R2 out0", v, 8'h3C);
    rd_reg(3'd3, v); chk("R2 out1", v, 8'hA1);
    rd_reg(3'd4, v); chk("R2 pol0", v, 8'h0F);
    rd_reg(3'd5, v); chk("R2 pol1", v, 8'hF0);
    chk("R5 hold", rdata, 8'hF0);
  endtask

  task automatic t_polarity;
    logic [7:0] v;
    pins = 16'h1234; tick(3);
    rd_reg(3'd0, v); chk("R5 in0 inv", v, 8'h34 ^ 8'h0F);
    rd_reg(3'd1, v); chk("R5 in1 inv", v, 8'h12 ^ 8'hF0);
    wr_reg(3'd4, 8'h00); wr_reg(3'd5, 8'h00);
    rd_reg(3'd0, v); chk("R5 in0 plain", v, 8'h34);
    chk("R7 no int", intn, 1'b1);
  endtask

  task automatic t_in_write;
    logic [7:0] v;
    wr_reg(3'd0, 8'hFF);
    chk("R3 int after in write", intn, 1'b1);
    rd_reg(3'd0, v); chk("R3 in0 unchanged", v, 8'h34);
    wr_reg(3'd1, 8'h00);
    chk("R3 int after in1 write", intn, 1'b1);
  endtask

  task automatic t_outputs;
    wr_reg(3'd2, 8'hA5);
    wr_reg(3'd6, 8'h0F);
    chk("R4 oe", poe, 16'h00F0);
    chk("R4 pin_o", pout[7:4], 4'hA);
    wr_reg(3'd7, 8'h7F);
    chk("R4 oe p1", poe, 16'h80F0);
    chk("R4 pin_o p1", pout[15], 1'b1);
  endtask

  task automatic t_int_latency;
    logic [7:0] v;
    pins[15] = 1'b0; tick(3);
    chk("R10 out pin ignored", intn, 1'b1);
    pins[4] = ~pins[4]; tick(3);
    chk("R10 out pin p0 ignored", intn, 1'b1);
    pins[0] = ~pins[0];
    @(negedge clk); chk("R11 one edge", intn, 1'b1);
    @(negedge clk); chk("R7 two edges", intn, 1'b0);
    rd_reg(3'd1, v); chk("R8 other port keeps int", intn, 1'b0);
    rd_reg(3'd0, v); chk("R8 read clears", intn, 1'b1);
    pins[9] = ~pins[9]; tick(2);
    chk("R7 port1 int", intn, 1'b0);
    pins[9] = ~pins[9]; tick(2);
    chk("R9 return clears", intn, 1'b1);
  endtask

  initial begin
    tick(3);
    rst_n = 1;
    tick(5);
    t_reset();
    t_regmap();
    t_polarity();
    t_in_write();
    t_outputs();
    t_int_latency();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule